// File: doc/BRIEF.md
# Battery RAM Rotate-Add Checksum Engine

This engine seals or checks a small battery-backed settings RAM with a 16-bit rotate-and-add checksum. The four highest bytes of the RAM are reserved. They hold the checksum and a second copy of it XORed with a fixed mask. Every byte below those four is covered by the sum. The engine reaches the RAM over a byte-wide synchronous port with one cycle of read latency, and it is the only master on that port while it runs.

The sum is accumulated over little-endian 16-bit words. The first word begins six bytes below the top of the RAM, and the word start then steps down one byte at a time until it reaches offset 0. For each word the 17-bit value {carry, accumulator} is rotated left by one place, and the word is then added in together with the carry. Adjacent words share a byte, so after the first word only one new byte has to be read per step.

A pulse on `start_i` begins a run, and `verify_i` chooses the mode at that moment. In store mode the four reserved bytes are written. In verify mode they are read back and compared. The engine moves through the states IDLE, PRIME, WALK, TAIL, then STORE or CHECK, then DONE. The transitions are as follows:
- IDLE goes to PRIME on an accepted start.
- PRIME presents the top byte of the first word and goes to WALK.
- WALK stays in place, one cycle per byte, until offset 0 has been presented, and then goes to TAIL.
- TAIL folds in the word at offset 0 and branches on the mode.
- STORE lasts four cycles and CHECK lasts five, and both end in DONE.
- DONE returns to IDLE.

Top module: `bram_sum_engine`

## Requirements
- R1: While reset is applied and after it is released, `done_o`, `valid_o` and `mem_we_o` are all 0.
- R2: A store run writes the checksum to RAM offset DEPTH-4 (low byte) and DEPTH-3 (high byte). The checksum is computed as follows:
  - The accumulator and the carry both start at 0.
  - For each word start p, from DEPTH-6 down to 0 (DEPTH-5 steps in all), the word is {RAM[p+1], RAM[p]}.
  - At each step, {carry, acc} is rotated left by one place, and then acc + word + carry gives the new acc, with the carry taken out of bit 16.
- R3: A store run writes checksum XOR MASK (default 0xAAAA) to offset DEPTH-2 (low byte) and DEPTH-1 (high byte).
- R4: A store run writes only the four top bytes, in ascending address order, and leaves offsets 0 to DEPTH-5 unchanged.
- R5: At the end of a verify run, `valid_o` is 1 when both stored values equal a fresh computation. `valid_o` holds its value until the next accepted start, which clears it to 0.
- R6: A verify run gives `valid_o` = 0 when any of the four stored bytes, or any covered data byte, disagrees with the checksum rule.
- R7: A verify run never asserts `mem_we_o`, and it leaves the RAM contents unchanged.
- R8: A start pulse is ignored while a run is in progress. It neither restarts the run nor produces a second `done_o`.
- R9: `done_o` is a single-cycle pulse. It is high DEPTH+1 rising edges after the edge that samples start in store mode, and DEPTH+2 edges after it in verify mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run; sampled only in IDLE |
| verify_i | input | 1 | Mode captured at start: 0 store, 1 verify |
| done_o | output | 1 | One-cycle pulse when the run has finished |
| valid_o | output | 1 | Result of the last verify run |
| mem_addr_o | output | ADDR_W | RAM byte address |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the address |

## Verification
The bench builds the engine with its default parameters: an 8-bit address (256 bytes, 251 steps) and a mask of 0xAAAA. These defaults bring the full-length walk within reach. They also cover all-ones data, where the carry ripples on every step, and all-zero data, where the stored pair is exactly 0x0000 and 0xAAAA. Flipping each reserved byte in turn, and flipping one covered data byte, exercises every compare position. A start pulse injected in the middle of the walk probes the busy lockout.

// File: rtl/bram_sum_pkg.sv
package bram_sum_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_WALK,
        ST_TAIL,
        ST_STORE,
        ST_CHECK,
        ST_DONE
    } sum_state_e;
endpackage

// File: rtl/bram_sum_step.sv
// One rotate-through-carry followed by add-with-carry.
module bram_sum_step
    import bram_sum_pkg::*;
(
    input  logic [WORD_W-1:0] acc_i,
    input  logic              carry_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] acc_o,
    output logic              carry_o
);
    logic [WORD_W-1:0] rotated;
    logic              mid_carry;
    logic [WORD_W:0]   total;

    always_comb begin
        rotated   = {acc_i[WORD_W-2:0], carry_i};
        mid_carry = acc_i[WORD_W-1];
        total     = {1'b0, rotated} + {1'b0, word_i} + {{WORD_W{1'b0}}, mid_carry};
        acc_o     = total[WORD_W-1:0];
        carry_o   = total[WORD_W];
    end
endmodule

// File: rtl/bram_sum_acc.sv
// Accumulator, carry and held upper byte of the current word.
module bram_sum_acc
    import bram_sum_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clear_i,
    input  logic              load_hi_i,
    input  logic              step_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [WORD_W-1:0] sum_o
);
    logic [WORD_W-1:0] acc_q, acc_n;
    logic              carry_q, carry_n;
    logic [BYTE_W-1:0] hi_q;

    bram_sum_step u_step (
        .acc_i   (acc_q),
        .carry_i (carry_q),
        .word_i  ({hi_q, byte_i}),
        .acc_o   (acc_n),
        .carry_o (carry_n)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
            hi_q    <= '0;
        end else if (clear_i) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (load_hi_i || step_i) hi_q <= byte_i;
            if (step_i) begin
                acc_q   <= acc_n;
                carry_q <= carry_n;
            end
        end
    end

    assign sum_o = acc_q;
endmodule

// File: rtl/bram_sum_ctrl.sv
// Sequencer: walk pointer, reserved-byte index and RAM strobes.
module bram_sum_ctrl
    import bram_sum_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              verify_i,
    output sum_state_e        state_o,
    output logic [2:0]        idx_o,
    output logic              mode_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              we_o,
    output logic              clear_o,
    output logic              load_hi_o,
    output logic              step_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] WALK_TOP = ADDR_W'(DEPTH - 6);
    localparam logic [ADDR_W-1:0] PRIME_AD = ADDR_W'(DEPTH - 5);
    localparam logic [ADDR_W-1:0] SEAL_LO  = ADDR_W'(DEPTH - 4);

    sum_state_e        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q, ptr_d;
    logic [2:0]        idx_q, idx_d;
    logic              first_q, first_d;
    logic              mode_q, mode_d;

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        idx_d   = idx_q;
        first_d = first_q;
        mode_d  = mode_q;
        unique case (state_q)
            ST_IDLE: if (start_i) begin
                state_d = ST_PRIME;
                mode_d  = verify_i;
            end
            ST_PRIME: begin
                state_d = ST_WALK;
                ptr_d   = WALK_TOP;
                first_d = 1'b1;
            end
            ST_WALK: begin
                first_d = 1'b0;
                if (ptr_q == '0) state_d = ST_TAIL;
                else             ptr_d   = ptr_q - ADDR_W'(1);
            end
            ST_TAIL: begin
                idx_d   = '0;
                state_d = mode_q ? ST_CHECK : ST_STORE;
            end
            ST_STORE: begin
                idx_d = idx_q + 3'd1;
                if (idx_q == 3'd3) state_d = ST_DONE;
            end
            ST_CHECK: begin
                idx_d = idx_q + 3'd1;
                if (idx_q == 3'd4) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            idx_q   <= '0;
            first_q <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            idx_q   <= idx_d;
            first_q <= first_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        addr_o    = '0;
        we_o      = 1'b0;
        clear_o   = 1'b0;
        load_hi_o = 1'b0;
        step_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  clear_o = start_i;
            ST_PRIME: addr_o  = PRIME_AD;
            ST_WALK: begin
                addr_o    = ptr_q;
                load_hi_o = first_q;
                step_o    = !first_q;
            end
            ST_TAIL:  step_o = 1'b1;
            ST_STORE: begin
                addr_o = SEAL_LO + ADDR_W'(idx_q[1:0]);
                we_o   = 1'b1;
            end
            ST_CHECK: addr_o = SEAL_LO + ADDR_W'(idx_q[1:0]);
            ST_DONE:  addr_o = '0;
            default:  addr_o = '0;
        endcase
    end

    assign state_o = state_q;
    assign idx_o   = idx_q;
    assign mode_o  = mode_q;
endmodule

// File: rtl/bram_sum_engine.sv
module bram_sum_engine
    import bram_sum_pkg::*;
#(
    parameter int               ADDR_W = 8,
    parameter logic [15:0]      MASK   = 16'hAAAA
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              verify_i,
    output logic              done_o,
    output logic              valid_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam int SEAL_BYTES = 4;

    sum_state_e        state;
    logic [2:0]        idx;
    logic              mode;
    logic              clear, load_hi, step;
    logic [WORD_W-1:0] sum;
    logic [2*WORD_W-1:0] seal;
    logic [BYTE_W-1:0] seal_byte [SEAL_BYTES];
    logic [2:0]        idx_prev;
    logic              cur_miss;
    logic              miss_q, valid_q;

    bram_sum_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .verify_i  (verify_i),
        .state_o   (state),
        .idx_o     (idx),
        .mode_o    (mode),
        .addr_o    (mem_addr_o),
        .we_o      (mem_we_o),
        .clear_o   (clear),
        .load_hi_o (load_hi),
        .step_o    (step)
    );

    bram_sum_acc u_acc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (clear),
        .load_hi_i (load_hi),
        .step_i    (step),
        .byte_i    (mem_rdata_i),
        .sum_o     (sum)
    );

    assign seal = {sum ^ MASK, sum};

    for (genvar k = 0; k < SEAL_BYTES; k++) begin : g_seal
        assign seal_byte[k] = seal[k*BYTE_W +: BYTE_W];
    end

    assign idx_prev    = idx - 3'd1;
    assign cur_miss    = (state == ST_CHECK) && (idx != 3'd0) &&
                         (mem_rdata_i != seal_byte[idx_prev[1:0]]);
    assign mem_wdata_o = seal_byte[idx[1:0]];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            miss_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (clear) begin
            miss_q  <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            if (cur_miss) miss_q <= 1'b1;
            if (state == ST_CHECK && idx == 3'd4)
                valid_q <= mode && !(miss_q || cur_miss);
        end
    end

    assign done_o  = (state == ST_DONE);
    assign valid_o = valid_q;
endmodule

// File: rtl/bram_sum_engine_chk.sv
module bram_sum_engine_chk
    import bram_sum_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              start_i,
    input logic              done_o,
    input logic              valid_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mode,
    input sum_state_e        state
);
    localparam logic [ADDR_W-1:0] SEAL_LO = ADDR_W'((1 << ADDR_W) - 4);

    // R4: writes land only in the reserved top bytes
    p_we_top_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |-> (mem_addr_o >= SEAL_LO));

    // R4: reserved bytes are written in ascending order, back to back
    p_store_ascending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |=> done_o || (mem_we_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));

    // R7: a verify run never writes
    p_no_write_verify_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode && state != ST_IDLE) |-> !mem_we_o);

    // R9: done lasts one cycle
    p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R5: valid moves only at the end of a run or on an accepted start
    p_valid_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(valid_o) |-> (done_o || $past(start_i)));

    // R8: a busy engine never re-enters the priming state
    p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state != ST_IDLE) |=> (state != ST_PRIME));

    // R1: no write strobe in the idle state
    p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_IDLE) |-> !mem_we_o);
endmodule

bind bram_sum_engine bram_sum_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .done_o     (done_o),
    .valid_o    (valid_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mode       (mode),
    .state      (state)
);

// File: tb/bram_sum_engine_bench.sv
`timescale 1ns/1ps
module bram_sum_engine_bench;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SLO   = DEPTH - 4;
    localparam int NVEC  = 6;
    // {kind[1:0], seed[7:0]}: kind 0 constant, 1 ramp, 2 hash
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd0, 8'h00}, {2'd0, 8'hFF}, {2'd1, 8'h00},
        {2'd1, 8'h80}, {2'd2, 8'h37}, {2'd2, 8'hC5}
    };

    logic clk = 0, rst_n = 0, start = 0, verify = 0;
    logic done, valid, we;
    logic [AW-1:0] addr;
    logic [7:0] wdata, rdata;
    logic [7:0] mem  [DEPTH];
    logic [7:0] snap [DEPTH];
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    bram_sum_engine u_bram_sum_engine (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .verify_i(verify),
        .done_o(done), .valid_o(valid), .mem_addr_o(addr), .mem_we_o(we),
        .mem_wdata_o(wdata), .mem_rdata_i(rdata)
    );

    always @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_sum();
        logic [15:0] acc = 16'h0;
        logic        c = 1'b0;
        logic        top;
        logic [16:0] s;
        for (int p = DEPTH - 6; p >= 0; p--) begin
            top = acc[15];
            acc = {acc[14:0], c};
            c   = top;
            s   = {1'b0, acc} + {1'b0, mem[p+1], mem[p]} + {16'h0, c};
            acc = s[15:0];
            c   = s[16];
        end
        return acc;
    endfunction

    task automatic fill(input logic [1:0] kind, input logic [7:0] seed);
        for (int i = 0; i < DEPTH; i++) begin
            case (kind)
                2'd0:    mem[i] = seed;
                2'd1:    mem[i] = 8'(i) + seed;
                default: mem[i] = (8'(i) * seed + 8'(i >> 3)) ^ 8'h5A;
            endcase
        end
    endtask

    task automatic take_snap();
        for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
    endtask

    task automatic run(input bit ver, input int poke_at, output int lat);
        @(negedge clk);
        verify = ver;
        start  = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        lat = 0;
        while (!done && lat < 5000) begin
            start = (lat == poke_at);
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        start = 0;
    endtask

    task automatic diff_count(input int lo, input int hi, output int n);
        n = 0;
        for (int i = lo; i <= hi; i++) if (mem[i] !== snap[i]) n++;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        int lat, nd, pulses;
        logic [15:0] s;
        logic exp_v;
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 done in reset", done, 0);
        chk("R1 valid in reset", valid, 0);
        chk("R1 we in reset", we, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1 done after reset", done, 0);
        chk("R1 valid after reset", valid, 0);
        chk("R1 we after reset", we, 0);

        for (int v = 0; v < NVEC; v++) begin
            fill(VEC[v][9:8], VEC[v][7:0]);
            s = ref_sum();
            take_snap();
            run(0, -1, lat);
            chk("R9 store latency", lat, DEPTH + 1);
            @(negedge clk);
            chk("R9 done pulse width", done, 0);
            chk("R2 checksum bytes", {mem[SLO+1], mem[SLO]}, s);
            chk("R3 masked copy", {mem[SLO+3], mem[SLO+2]}, s ^ 16'hAAAA);
            diff_count(0, SLO - 1, nd);
            chk("R4 data untouched", nd, 0);
            take_snap();
            run(1, -1, lat);
            chk("R9 verify latency", lat, DEPTH + 2);
            chk("R5 valid after verify", valid, 1);
            repeat (5) @(negedge clk);
            chk("R5 valid held", valid, 1);
            diff_count(0, DEPTH - 1, nd);
            chk("R7 verify leaves ram", nd, 0);
        end

        // R5: accepted start clears valid
        @(negedge clk); verify = 0; start = 1;
        @(negedge clk); start = 0;
        chk("R5 valid cleared on start", valid, 0);
        while (!done) @(negedge clk);
        @(negedge clk);

        // R6: corrupt each reserved byte, then one covered byte
        for (int k = 0; k < 5; k++) begin
            int a;
            a = (k < 4) ? SLO + k : 3;
            mem[a] = mem[a] ^ 8'h01;
            s = ref_sum();
            exp_v = ({mem[SLO+1], mem[SLO]} == s) &&
                    ({mem[SLO+3], mem[SLO+2]} == (s ^ 16'hAAAA));
            take_snap();
            run(1, -1, lat);
            chk("R6 corrupted verify", valid, exp_v);
            diff_count(0, DEPTH - 1, nd);
            chk("R7 no write on failed verify", nd, 0);
            mem[a] = mem[a] ^ 8'h01;
        end

        // R8: start pulse in the middle of a store run
        fill(2'd2, 8'h91);
        s = ref_sum();
        run(0, 40, lat);
        chk("R8 latency with busy start", lat, DEPTH + 1);
        pulses = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) pulses++;
        end
        chk("R8 no second done", pulses, 0);
        chk("R8 checksum intact", {mem[SLO+1], mem[SLO]}, s);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule